// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides, on every cycle, whether an interrupt request should go to the processor. It keeps an in-service register, with one bit for each request line, and a rotation base that says which line currently has the top priority. The pending vector and the mask vector arrive from outside. The block takes the highest-ranked unmasked pending line and raises its request only when that line ranks strictly above every line still counted as in service. The set of lines counted as in service can be trimmed in two ways. The first is a special-mask mode, which ignores the in-service bits of masked lines. The second applies on a cascade master: a fully-nested mode there ignores the in-service bit of the cascade line.

An acknowledge strobe takes the winning line into service. In auto-EOI mode the acknowledge leaves the in-service register alone and can instead rotate the base. A command decoder outside the block supplies end-of-interrupt and rotation commands as a 3-bit code and a line number. The resolver output is combinational from the registered state. Every update of the in-service register and the base takes effect at the next rising clock edge.

Top module: `irq_rank_resolver`

## Requirements
- R1: The rank of line n is (n − base) mod 8, where rank 0 is the highest. When `irq_o` is high, `irq_line_o` equals (winning rank + base) mod 8.
- R2: Only lines with the pending bit set and the mask bit clear can win. A masked line never appears on `irq_line_o` while `irq_o` is high.
- R3: With `smask_en_i` high, the in-service bits of masked lines are left out of the in-service comparison.
- R4: With `fnest_en_i` and `is_master_i` both high, in-service bit 2 (the cascade line) is left out of the in-service comparison.
- R5: `irq_o` is high only when the winning candidate rank is strictly lower than the highest rank in the comparison set. An empty set counts as rank 8.
- R6: An acknowledge (`ack_i` high while `irq_o` is high) with `auto_eoi_i` low sets the in-service bit of the reported line at the next edge.
- R7: An acknowledge with `auto_eoi_i` high leaves the in-service register unchanged. If `rot_aeoi_i` is also high, the base becomes (line + 1) mod 8.
- R8: Command 1 clears the highest-ranked set in-service bit. Command 2 does the same and also sets the base to that line + 1. Either command changes nothing when the in-service register is empty.
- R9: Command 3 clears in-service bit `cmd_line_i`. Command 4 sets the base to `cmd_line_i` + 1. Command 5 does both.
- R10: Commands 0, 6 and 7 change nothing. An acknowledge while `irq_o` is low changes nothing. Any command is ignored in a cycle where `ack_i` is high.
- R11: After reset the in-service register is 0, the base is 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 8 | Pending request lines |
| mask_i | input | 8 | Mask bits, 1 = line masked |
| smask_en_i | input | 1 | Special-mask mode |
| fnest_en_i | input | 1 | Fully-nested cascade mode |
| is_master_i | input | 1 | This unit is the cascade master |
| auto_eoi_i | input | 1 | Auto end-of-interrupt mode |
| rot_aeoi_i | input | 1 | Rotate the base on an auto-EOI acknowledge |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_i | input | 3 | Command code (0..7, see R8 to R10) |
| cmd_line_i | input | 3 | Line operand of commands 3, 4 and 5 |
| irq_o | output | 1 | Request to the processor |
| irq_line_o | output | 3 | Winning line |
| isr_o | output | 8 | In-service register |
| base_o | output | 3 | Rotation base |

## Verification
Directed sequences come first. They cover nesting, where a higher-ranked line interrupts an in-service line, and blocking, where a line of equal or lower rank waits. They also cover clearing by non-specific and by specific commands, base rotation by command and by auto-EOI, and cases that show the difference between special mask and cascade exclusion. A sweep then walks all 32 combinations of the five mode inputs, with pseudo-random pending, mask, acknowledge and command traffic under each one. The sweep separates errors in rank wrap-around from errors in the strictness of the comparison and from errors in which bits each exclusion removes. An arithmetic reference model checks every output on every cycle.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;
    localparam int unsigned LINES = 8;
    localparam int unsigned IDX_W = $clog2(LINES);

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_EOI      = 3'd1,
        CMD_EOI_ROT  = 3'd2,
        CMD_CLR_LINE = 3'd3,
        CMD_SET_BASE = 3'd4,
        CMD_CLR_ROT  = 3'd5,
        CMD_RSV6     = 3'd6,
        CMD_RSV7     = 3'd7
    } rank_cmd_e;

    typedef struct packed {
        logic [LINES-1:0] isr;
        logic [IDX_W-1:0] base;
    } rank_state_t;
endpackage

// File: rtl/irq_rank_search.sv
// Finds the lowest rank (relative to base) of any set bit; returns N if empty.
module irq_rank_search #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  set_i,
    input  logic [IW-1:0] base_i,
    output logic [IW:0]   rank_o
);
    logic [IW-1:0] line;

    always_comb begin
        rank_o = (IW+1)'(N);
        line   = '0;
        for (int p = N - 1; p >= 0; p--) begin
            line = base_i + IW'(p);
            if (set_i[line]) begin
                rank_o = (IW+1)'(p);
            end
        end
    end
endmodule

// File: rtl/irq_cmp_filter.sv
// Builds the in-service comparison set after the mask and cascade exclusions.
module irq_cmp_filter #(
    parameter int unsigned N         = 8,
    parameter int unsigned CASC_LINE = 2
) (
    input  logic [N-1:0] isr_i,
    input  logic [N-1:0] mask_i,
    input  logic         smask_en_i,
    input  logic         fnest_en_i,
    input  logic         is_master_i,
    output logic [N-1:0] cmp_o
);
    logic [N-1:0] after_mask;

    assign after_mask = smask_en_i ? (isr_i & ~mask_i) : isr_i;

    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            if (g == CASC_LINE) begin : g_casc
                assign cmp_o[g] = after_mask[g] & ~(fnest_en_i & is_master_i);
            end else begin : g_plain
                assign cmp_o[g] = after_mask[g];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver
    import irq_rank_pkg::*;
#(
    parameter int unsigned CASC_LINE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pend_i,
    input  logic [LINES-1:0] mask_i,
    input  logic             smask_en_i,
    input  logic             fnest_en_i,
    input  logic             is_master_i,
    input  logic             auto_eoi_i,
    input  logic             rot_aeoi_i,
    input  logic             ack_i,
    input  logic [2:0]       cmd_i,
    input  logic [IDX_W-1:0] cmd_line_i,
    output logic             irq_o,
    output logic [IDX_W-1:0] irq_line_o,
    output logic [LINES-1:0] isr_o,
    output logic [IDX_W-1:0] base_o
);
    rank_state_t state_d, state_q;

    logic [LINES-1:0] cand_set, cmp_set;
    logic [IDX_W:0]   cand_rank, cur_rank, eoi_rank;
    logic [IDX_W-1:0] win_line, eoi_line;
    logic             req;
    rank_cmd_e        cmd;

    assign cmd      = rank_cmd_e'(cmd_i);
    assign cand_set = pend_i & ~mask_i;

    irq_cmp_filter #(.N(LINES), .CASC_LINE(CASC_LINE)) i_filter (
        .isr_i       (state_q.isr),
        .mask_i      (mask_i),
        .smask_en_i  (smask_en_i),
        .fnest_en_i  (fnest_en_i),
        .is_master_i (is_master_i),
        .cmp_o       (cmp_set)
    );

    irq_rank_search #(.N(LINES), .IW(IDX_W)) i_cand_search (
        .set_i  (cand_set),
        .base_i (state_q.base),
        .rank_o (cand_rank)
    );

    irq_rank_search #(.N(LINES), .IW(IDX_W)) i_cur_search (
        .set_i  (cmp_set),
        .base_i (state_q.base),
        .rank_o (cur_rank)
    );

    irq_rank_search #(.N(LINES), .IW(IDX_W)) i_eoi_search (
        .set_i  (state_q.isr),
        .base_i (state_q.base),
        .rank_o (eoi_rank)
    );

    assign req      = cand_rank < cur_rank;
    assign win_line = state_q.base + cand_rank[IDX_W-1:0];
    assign eoi_line = state_q.base + eoi_rank[IDX_W-1:0];

    always_comb begin
        state_d = state_q;
        if (ack_i) begin
            if (req) begin
                if (!auto_eoi_i) begin
                    state_d.isr[win_line] = 1'b1;
                end else if (rot_aeoi_i) begin
                    state_d.base = win_line + IDX_W'(1);
                end
            end
        end else begin
            unique case (cmd)
                CMD_EOI, CMD_EOI_ROT: begin
                    if (!eoi_rank[IDX_W]) begin
                        state_d.isr[eoi_line] = 1'b0;
                        if (cmd == CMD_EOI_ROT) begin
                            state_d.base = eoi_line + IDX_W'(1);
                        end
                    end
                end
                CMD_CLR_LINE: state_d.isr[cmd_line_i] = 1'b0;
                CMD_SET_BASE: state_d.base = cmd_line_i + IDX_W'(1);
                CMD_CLR_ROT: begin
                    state_d.isr[cmd_line_i] = 1'b0;
                    state_d.base            = cmd_line_i + IDX_W'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o      = req;
    assign irq_line_o = win_line;
    assign isr_o      = state_q.isr;
    assign base_o     = state_q.base;
endmodule

// File: rtl/irq_rank_checker.sv
module irq_rank_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] pend_i,
    input logic [7:0] mask_i,
    input logic       fnest_en_i,
    input logic       is_master_i,
    input logic       auto_eoi_i,
    input logic       rot_aeoi_i,
    input logic       ack_i,
    input logic [2:0] cmd_i,
    input logic       irq_o,
    input logic [2:0] irq_line_o,
    input logic [7:0] isr_o,
    input logic [2:0] base_o
);
    assert_winner_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_i[irq_line_o] && !mask_i[irq_line_o]));

    assert_winner_not_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(fnest_en_i && is_master_i && irq_line_o == 3'd2)) |-> !isr_o[irq_line_o]);

    assert_ack_sets_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !auto_eoi_i) |=> isr_o[$past(irq_line_o)]);

    assert_aeoi_keeps_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && auto_eoi_i) |=> $stable(isr_o));

    assert_aeoi_rotates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && auto_eoi_i && rot_aeoi_i) |=> (base_o == $past(irq_line_o) + 3'd1));

    assert_idle_cmd_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && (cmd_i == 3'd0 || cmd_i == 3'd6 || cmd_i == 3'd7)) |=> ($stable(isr_o) && $stable(base_o)));
endmodule

bind irq_rank_resolver irq_rank_checker i_irq_rank_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend_i),
    .mask_i      (mask_i),
    .fnest_en_i  (fnest_en_i),
    .is_master_i (is_master_i),
    .auto_eoi_i  (auto_eoi_i),
    .rot_aeoi_i  (rot_aeoi_i),
    .ack_i       (ack_i),
    .cmd_i       (cmd_i),
    .irq_o       (irq_o),
    .irq_line_o  (irq_line_o),
    .isr_o       (isr_o),
    .base_o      (base_o)
);

// File: tb/test_irq_rank_resolver.sv
module test_irq_rank_resolver;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pend_i = '0, mask_i = '0;
    logic       smask_en_i = 1'b0, fnest_en_i = 1'b0, is_master_i = 1'b0;
    logic       auto_eoi_i = 1'b0, rot_aeoi_i = 1'b0, ack_i = 1'b0;
    logic [2:0] cmd_i = '0, cmd_line_i = '0;
    logic       irq_o;
    logic [2:0] irq_line_o, base_o;
    logic [7:0] isr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_isr;
    logic [2:0] m_base;
    logic [31:0] rng = 32'h1badf00d;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_rank_resolver i_irq_rank_resolver (
        .clk, .rst_n, .pend_i, .mask_i, .smask_en_i, .fnest_en_i, .is_master_i,
        .auto_eoi_i, .rot_aeoi_i, .ack_i, .cmd_i, .cmd_line_i,
        .irq_o, .irq_line_o, .isr_o, .base_o
    );

    function automatic int rank_of(logic [7:0] s, logic [2:0] b);
        for (int p = 0; p < 8; p++) begin
            if (s[(b + p) % 8]) return p;
        end
        return 8;
    endfunction

    function automatic logic [31:0] next_rng(logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13;
        y ^= y >> 17;
        y ^= y << 5;
        return y;
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Drive one cycle of stimulus, check outputs against the model, then advance the model.
    task automatic step(string tag, logic [7:0] pend, logic [7:0] mask, logic [4:0] modes,
                        logic ack, logic [2:0] cmd, logic [2:0] cline);
        logic [7:0] cand, cmp;
        int cp, ip, r;
        logic req;
        logic [2:0] line, eline;
        @(negedge clk);
        pend_i = pend; mask_i = mask; ack_i = ack; cmd_i = cmd; cmd_line_i = cline;
        {smask_en_i, fnest_en_i, is_master_i, auto_eoi_i, rot_aeoi_i} = modes;
        #1;
        cand = pend & ~mask;
        cmp  = m_isr;
        if (modes[4]) cmp = cmp & ~mask;
        if (modes[3] && modes[2]) cmp[2] = 1'b0;
        cp   = rank_of(cand, m_base);
        ip   = rank_of(cmp, m_base);
        req  = cp < ip;
        line = 3'((cp + m_base) % 8);
        check(tag, "irq", int'(irq_o), int'(req));
        if (req) check(tag, "line", int'(irq_line_o), int'(line));
        check(tag, "isr", int'(isr_o), int'(m_isr));
        check(tag, "base", int'(base_o), int'(m_base));
        if (ack) begin
            if (req) begin
                if (!modes[1]) m_isr[line] = 1'b1;
                else if (modes[0]) m_base = line + 3'd1;
            end
        end else begin
            case (cmd)
                3'd1, 3'd2: begin
                    r = rank_of(m_isr, m_base);
                    if (r != 8) begin
                        eline = 3'((r + m_base) % 8);
                        m_isr[eline] = 1'b0;
                        if (cmd == 3'd2) m_base = eline + 3'd1;
                    end
                end
                3'd3: m_isr[cline] = 1'b0;
                3'd4: m_base = cline + 3'd1;
                3'd5: begin m_isr[cline] = 1'b0; m_base = cline + 3'd1; end
                default: ;
            endcase
        end
    endtask

    initial begin
        m_isr = '0; m_base = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "isr", int'(isr_o), 0);
        check("R11", "base", int'(base_o), 0);
        check("R11", "irq", int'(irq_o), 0);
        rst_n = 1'b1;

        step("R1",  8'h28, 8'h00, 5'b00000, 0, 3'd0, 3'd0);
        step("R2",  8'h28, 8'h08, 5'b00000, 0, 3'd0, 3'd0);
        step("R6",  8'h28, 8'h00, 5'b00000, 1, 3'd0, 3'd0);
        step("R5",  8'h28, 8'h00, 5'b00000, 0, 3'd0, 3'd0);
        step("R5",  8'h02, 8'h00, 5'b00000, 0, 3'd0, 3'd0);
        step("R3",  8'h20, 8'h08, 5'b10000, 0, 3'd0, 3'd0);
        step("R8",  8'h00, 8'h00, 5'b00000, 0, 3'd1, 3'd0);
        step("R8",  8'h00, 8'h00, 5'b00000, 0, 3'd1, 3'd0);
        step("R9",  8'h00, 8'h00, 5'b00000, 0, 3'd4, 3'd4);
        step("R1",  8'h11, 8'h00, 5'b00000, 0, 3'd0, 3'd0);
        step("R7",  8'h11, 8'h00, 5'b00011, 1, 3'd0, 3'd0);
        step("R7",  8'h11, 8'h00, 5'b00000, 0, 3'd0, 3'd0);
        step("R10", 8'h00, 8'h00, 5'b00000, 1, 3'd5, 3'd1);
        step("R10", 8'h04, 8'h00, 5'b00000, 1, 3'd3, 3'd2);
        step("R4",  8'h04, 8'h00, 5'b00000, 0, 3'd0, 3'd0);
        step("R4",  8'h04, 8'h00, 5'b01100, 0, 3'd0, 3'd0);
        step("R10", 8'h04, 8'h00, 5'b00000, 0, 3'd6, 3'd2);
        step("R9",  8'h04, 8'h00, 5'b00000, 0, 3'd5, 3'd2);
        step("R8",  8'h00, 8'h00, 5'b00000, 0, 3'd2, 3'd0);
        step("R9",  8'h00, 8'h00, 5'b00000, 0, 3'd3, 3'd0);

        // Sweep every mode combination with pseudo-random traffic (R1..R10 all covered).
        for (int blk = 0; blk < 32; blk++) begin
            for (int c = 0; c < 400; c++) begin
                logic [7:0] p, mk;
                logic a;
                logic [2:0] cm;
                rng = next_rng(rng); p  = rng[7:0]; mk = rng[15:8] & rng[23:16];
                a   = rng[25:24] == 2'b00;
                cm  = rng[28] ? rng[31:29] : 3'd0;
                rng = next_rng(rng);
                step("R1/R5", p, mk, 5'(blk), a, cm, rng[2:0]);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule